// File: doc/BRIEF.md
# Divided-Oscillator Jitter Sampler

This block turns the phase jitter between free-running oscillators into a stream of random bits for the system clock domain. A reference oscillator is divided by a run-time factor K to make a slow sampling strobe. On each strobe, a capture register samples the sampled oscillators. With several oscillators the register takes their XOR; with one oscillator it takes that oscillator directly. Across the K reference periods between captures, jitter builds up, so one bit comes out per divided period. A larger K gives more accumulated noise and a lower bit rate.

Each captured bit crosses into the system clock domain as a toggle. The toggle passes a two-flop synchronizer and an edge detector, which produce a one-cycle `bit_valid` pulse with the bit on `bit_data`. Raising `enable` starts the divider. Lowering it holds the divider and the captured bit in reset and blocks all pulses. K is latched only while the divider is held, so a change never cuts a sampling period short.

The divider is a two-state machine clocked by the reference oscillator:
- DIV_HOLD: the counter is at zero and K is (re)latched. The transition *start* to DIV_RUN is taken when the synchronized enable is high.
- DIV_RUN: the divider counts reference edges from 0 to K-1 and fires the strobe on the wrap edge. The transition *stop* back to DIV_HOLD is taken when the synchronized enable is low.

The bit crossing assumes that K reference periods span at least three system clock periods.

Top module: `jsamp_top`

## Requirements
- R1: While `rst_n` is low, and after its release with `enable` low, `bit_valid` and `bit_data` are 0.
- R2: With `enable` high and an effective K of 2 or more, `bit_valid` pulses are exactly one system cycle wide and arrive once every K reference-oscillator periods.
- R3: With NUM_OSC > 1, the bit delivered with a pulse equals the XOR (odd parity) of all `samp_osc` bits at the capture edge.
- R4: With NUM_OSC = 1, the bit delivered equals `samp_osc[0]` at the capture edge.
- R5: A `div_k` value of 0 or 1 behaves as K = 2.
- R6: A change of `div_k` while enabled has no effect on the pulse spacing. The new value takes effect only after `enable` has been low and then high again.
- R7: While `enable` is low, no `bit_valid` pulse appears and `bit_data` holds its value.
- R8: `bit_data` changes only in cycles where `bit_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| enable | input | 1 | Run control (system domain) |
| div_k | input | K_W | Division factor K, latched while the divider is held |
| ref_osc | input | 1 | Reference oscillator, clocks the divider |
| samp_osc | input | NUM_OSC | Sampled oscillators |
| bit_valid | output | 1 | One-cycle pulse per delivered random bit |
| bit_data | output | 1 | Random bit, valid with `bit_valid` |

## Verification
The reference oscillator runs at exactly twice the system period. K values of 4, 6, 0 and 1 therefore map to fixed pulse spacings of 8, 12, 4 and 4 cycles, which separates an off-by-one wrap and a missing clamp from correct division. The sampled inputs are held at the parity patterns 000, 001, 011, 111, 100 and 110, and these tell a true XOR apart from an OR, an AND or a single tapped input. K is changed in mid-run to show that it is latched only in the hold state. A disabled window shows that no pulses appear and the bit does not move, and a single-oscillator instance covers the pass-through variant.

// File: rtl/jsamp_pkg.sv
package jsamp_pkg;

    typedef enum logic [0:0] {
        DIV_HOLD = 1'b0,
        DIV_RUN  = 1'b1
    } div_state_t;

    localparam int SYNC_STAGES = 2;

endpackage

// File: rtl/jsamp_sync2.sv
module jsamp_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/jsamp_divider.sv
module jsamp_divider
    import jsamp_pkg::*;
#(
    parameter int K_W = 16
) (
    input  logic           ref_osc,
    input  logic           rst_n,
    input  logic           run,
    input  logic [K_W-1:0] div_k,
    output logic           strobe
);
    localparam logic [K_W-1:0] K_MIN = K_W'(2);
    localparam logic [K_W-1:0] ONE   = K_W'(1);

    div_state_t     state, nxt;
    logic [K_W-1:0] cnt;
    logic [K_W-1:0] k_lat;

    always_ff @(posedge ref_osc or negedge rst_n) begin
        if (!rst_n) begin
            state <= DIV_HOLD;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            DIV_HOLD: if (run)  nxt = DIV_RUN;
            DIV_RUN:  if (!run) nxt = DIV_HOLD;
            default:  nxt = DIV_HOLD;
        endcase
    end

    always_ff @(posedge ref_osc or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            k_lat <= K_MIN;
        end else begin
            unique case (state)
                DIV_HOLD: begin
                    cnt   <= '0;
                    k_lat <= (div_k < K_MIN) ? K_MIN : div_k;
                end
                DIV_RUN: begin
                    if (!run || strobe) cnt <= '0;
                    else                cnt <= cnt + ONE;
                end
                default: cnt <= '0;
            endcase
        end
    end

    always_comb begin
        strobe = (state == DIV_RUN) && run && (cnt == k_lat - ONE);
    end
endmodule

// File: rtl/jsamp_capture.sv
module jsamp_capture #(
    parameter int NUM_OSC = 2
) (
    input  logic               ref_osc,
    input  logic               rst_n,
    input  logic               run,
    input  logic               strobe,
    input  logic [NUM_OSC-1:0] samp_osc,
    output logic               cap_bit,
    output logic               cap_toggle
);
    logic mixed;

    generate
        if (NUM_OSC == 1) begin : g_single
            assign mixed = samp_osc[0];
        end else begin : g_xor
            assign mixed = ^samp_osc;
        end
    endgenerate

    always_ff @(posedge ref_osc or negedge rst_n) begin
        if (!rst_n) begin
            cap_bit    <= 1'b0;
            cap_toggle <= 1'b0;
        end else if (!run) begin
            cap_bit    <= 1'b0;
        end else if (strobe) begin
            cap_bit    <= mixed;
            cap_toggle <= ~cap_toggle;
        end
    end
endmodule

// File: rtl/jsamp_top.sv
module jsamp_top
    import jsamp_pkg::*;
#(
    parameter int NUM_OSC = 2,
    parameter int K_W     = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [K_W-1:0]     div_k,
    input  logic               ref_osc,
    input  logic [NUM_OSC-1:0] samp_osc,
    output logic               bit_valid,
    output logic               bit_data
);
    logic run_ref;
    logic div_strobe;
    logic cap_bit;
    logic cap_toggle;
    logic tog_sys;
    logic tog_prev;
    logic edge_seen;

    jsamp_sync2 #(.STAGES(SYNC_STAGES)) u_en_sync (
        .clk   (ref_osc),
        .rst_n (rst_n),
        .d     (enable),
        .q     (run_ref)
    );

    jsamp_divider #(.K_W(K_W)) u_div (
        .ref_osc (ref_osc),
        .rst_n   (rst_n),
        .run     (run_ref),
        .div_k   (div_k),
        .strobe  (div_strobe)
    );

    jsamp_capture #(.NUM_OSC(NUM_OSC)) u_cap (
        .ref_osc    (ref_osc),
        .rst_n      (rst_n),
        .run        (run_ref),
        .strobe     (div_strobe),
        .samp_osc   (samp_osc),
        .cap_bit    (cap_bit),
        .cap_toggle (cap_toggle)
    );

    jsamp_sync2 #(.STAGES(SYNC_STAGES)) u_tog_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cap_toggle),
        .q     (tog_sys)
    );

    assign edge_seen = tog_sys ^ tog_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tog_prev  <= 1'b0;
            bit_valid <= 1'b0;
            bit_data  <= 1'b0;
        end else begin
            tog_prev  <= tog_sys;
            bit_valid <= enable && edge_seen;
            if (enable && edge_seen) bit_data <= cap_bit;
        end
    end
endmodule

// File: rtl/jsamp_chk.sv
module jsamp_chk (
    input logic clk,
    input logic ref_osc,
    input logic rst_n,
    input logic enable,
    input logic bit_valid,
    input logic bit_data,
    input logic div_strobe,
    input logic cap_toggle
);
    // R2
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |=> !bit_valid);

    // R7
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !bit_valid);

    // R8
    data_on_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bit_data) |-> bit_valid);

    // R2
    strobe_flip_chk: assert property (@(posedge ref_osc) disable iff (!rst_n)
        div_strobe |=> (cap_toggle != $past(cap_toggle)));

    // R2
    no_strobe_flip_chk: assert property (@(posedge ref_osc) disable iff (!rst_n)
        !div_strobe |=> $stable(cap_toggle));
endmodule

bind jsamp_top jsamp_chk u_chk (
    .clk        (clk),
    .ref_osc    (ref_osc),
    .rst_n      (rst_n),
    .enable     (enable),
    .bit_valid  (bit_valid),
    .bit_data   (bit_data),
    .div_strobe (div_strobe),
    .cap_toggle (cap_toggle)
);

// File: tb/jsamp_top_tb.sv
`timescale 1ns/1ps
module jsamp_top_tb;
    localparam int KW = 16;

    logic          clk = 1'b0;
    logic          ref_osc = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic [KW-1:0] div_k = KW'(4);
    logic [2:0]    samp = 3'b000;
    logic [0:0]    samp1 = 1'b0;
    logic          v, d, v1, d1;
    int            total = 0;
    int            bad = 0;

    always #2.5 clk = ~clk;
    initial begin
        #1;
        forever #5 ref_osc = ~ref_osc;
    end

    jsamp_top #(.NUM_OSC(3), .K_W(KW)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .div_k(div_k),
        .ref_osc(ref_osc), .samp_osc(samp), .bit_valid(v), .bit_data(d)
    );

    jsamp_top #(.NUM_OSC(1), .K_W(KW)) u_dut_single (
        .clk(clk), .rst_n(rst_n), .enable(enable), .div_k(div_k),
        .ref_osc(ref_osc), .samp_osc(samp1), .bit_valid(v1), .bit_data(d1)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_valid(input int maxc, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!v && n < maxc);
    endtask

    task automatic wait_valid1(input int maxc, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!v1 && n < maxc);
    endtask

    task automatic get_interval(output int n);
        int dummy;
        wait_valid(200, dummy);
        wait_valid(200, n);
    endtask

    task automatic restart(input logic [KW-1:0] k);
        enable = 1'b0;
        repeat (30) @(negedge clk);
        div_k  = k;
        enable = 1'b1;
    endtask

    task automatic t_reset();
        int pulses = 0;
        repeat (4) @(negedge clk);
        check("R1 valid in reset", int'(v), 0);
        check("R1 data in reset", int'(d), 0);
        rst_n = 1'b1;
        repeat (40) begin
            @(negedge clk);
            if (v || d) pulses++;
        end
        check("R1 idle after reset", pulses, 0);
    endtask

    task automatic t_interval();
        int n;
        restart(KW'(4));
        get_interval(n);
        check("R2 spacing K=4", n, 8);
        wait_valid(200, n);
        @(negedge clk);
        check("R2 pulse width", int'(v), 0);
        wait_valid(200, n);
        check("R2 spacing K=4 again", n + 1, 8);
    endtask

    task automatic t_k_change();
        int n;
        div_k = KW'(6);
        get_interval(n);
        check("R6 K ignored while running", n, 8);
        restart(KW'(6));
        get_interval(n);
        check("R6 K applied after restart", n, 12);
    endtask

    task automatic t_clamp();
        int n;
        restart(KW'(0));
        get_interval(n);
        check("R5 K=0 acts as 2", n, 4);
        restart(KW'(1));
        get_interval(n);
        check("R5 K=1 acts as 2", n, 4);
    endtask

    task automatic t_xor();
        logic [2:0] pats [6] = '{3'b000, 3'b001, 3'b011, 3'b111, 3'b100, 3'b110};
        int n;
        restart(KW'(4));
        foreach (pats[i]) begin
            samp = pats[i];
            wait_valid(200, n);
            wait_valid(200, n);
            check($sformatf("R3 parity of %b", pats[i]), int'(d), int'(^pats[i]));
        end
    endtask

    task automatic t_single();
        int n;
        samp1 = 1'b1;
        wait_valid1(200, n);
        wait_valid1(200, n);
        check("R4 single osc high", int'(d1), 1);
        samp1 = 1'b0;
        wait_valid1(200, n);
        wait_valid1(200, n);
        check("R4 single osc low", int'(d1), 0);
    endtask

    task automatic t_data_on_valid();
        int  bad_moves = 0;
        logic prev;
        @(negedge clk);
        prev = d;
        for (int c = 0; c < 300; c++) begin
            if (c % 5 == 0) samp = samp ^ 3'b001;
            @(negedge clk);
            if (d !== prev && !v) bad_moves++;
            prev = d;
        end
        check("R8 data moves only with valid", bad_moves, 0);
    endtask

    task automatic t_disable();
        int   pulses = 0;
        int   moves = 0;
        logic hold;
        enable = 1'b0;
        @(negedge clk);
        hold = d;
        for (int c = 0; c < 300; c++) begin
            samp = samp ^ 3'b011;
            @(negedge clk);
            if (v) pulses++;
            if (d !== hold) moves++;
        end
        check("R7 no pulses while disabled", pulses, 0);
        check("R7 data holds while disabled", moves, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_interval();
        t_k_change();
        t_clamp();
        t_xor();
        t_single();
        t_data_on_valid();
        t_disable();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule